// File: doc/BRIEF.md
# Memory Barrier Ordering Gate

This block sits between an in-order issue stage and the memory request port of a processor pipeline. Every instruction that is offered on the issue handshake carries a class (arithmetic, load, store or maintenance), a barrier kind and an access-type option. The gate counts outstanding loads, stores that may be acknowledged early, stores that need the endpoint response, and cache/TLB maintenance operations. Each count goes up when the operation issues and down on its own completion pulse. From these counts and a small state machine it decides, in the same cycle, whether the offered instruction is stalled and whether a memory request strobe goes out.

Three barriers are supported. An ordering barrier stops only later memory instructions of the affected types from overtaking earlier ones, and arithmetic keeps flowing. A synchronization barrier freezes every later instruction until the earlier memory work it watches has completed. A resync barrier freezes everything until all outstanding work has drained, then raises a one-cycle flush request so that the front end fetches again. Only one barrier is pending at a time.

The state machine has five states: `ST_IDLE` (no barrier pending), `ST_ORDER_WAIT`, `ST_SYNC_WAIT`, `ST_RESYNC_WAIT` and `ST_FLUSH`. Transitions: idle to one of the three wait states when a barrier is accepted; order-wait and sync-wait back to idle when the watched counters are all zero; resync-wait to flush when every counter is zero; flush to idle after one cycle.

Top module: `membar_gate`

## Requirements
- R1: After reset all four counters are zero, no barrier is pending, and `iss_stall`, `mem_req` and `flush_req` are low.
- R2: Class encoding is 2'b00 arithmetic, 2'b01 load, 2'b10 store, 2'b11 maintenance. Barrier encoding is 2'b00 none, 2'b01 ordering, 2'b10 synchronization, 2'b11 resync. When the barrier field is not none, the class is ignored. An accepted load, store or maintenance instruction raises `mem_req` in the same cycle; arithmetic instructions and barriers never do.
- R3: An instruction is accepted in a cycle where `iss_valid` is high and `iss_stall` is low. `iss_stall` is low whenever `iss_valid` is low.
- R4: While an ordering barrier is pending, arithmetic instructions issue. The held memory classes depend on the option: with 2'b00 full, loads, stores and maintenance are held; with 2'b01 loads-only, loads and stores are held; with 2'b10 stores-only, only stores are held.
- R5: An ordering barrier retires once the counters it watches all read zero: with full, loads and both store counters; with loads-only, the load counter only; with stores-only, both store counters. If the last completion pulse arrives in cycle t, a held instruction is accepted in cycle t+2.
- R6: While a synchronization barrier is pending, every instruction stalls, whatever its option. It watches the same counters as R5, and with the full option it also watches the maintenance counter.
- R7: Option 2'b11 behaves as full.
- R8: A store issued with `iss_early` high is counted down only by `st_ack_early`. A store issued with `iss_early` low is counted down only by `st_ack_end`.
- R9: A completion pulse for a counter that reads zero has no effect.
- R10: A resync barrier stalls every instruction until all four counters read zero. It then drives `flush_req` high for exactly one cycle while still stalling, and returns to idle.
- R11: While a barrier is pending, an offered barrier stalls.
- R12: Each counter saturates at 2^CNT_W-1. An instruction that would raise a full counter stalls until that counter drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue stage offers an instruction |
| iss_cls | input | 2 | Instruction class |
| iss_bar | input | 2 | Barrier kind |
| iss_opt | input | 2 | Barrier access-type option |
| iss_early | input | 1 | Store may be acknowledged early |
| iss_stall | output | 1 | Offered instruction is held this cycle |
| mem_req | output | 1 | Memory request strobe for an accepted memory instruction |
| flush_req | output | 1 | One-cycle pipeline flush and refetch request |
| ld_done | input | 1 | One load returned its data |
| st_ack_early | input | 1 | One early-acknowledged store completed |
| st_ack_end | input | 1 | One endpoint-acknowledged store completed |
| mnt_done | input | 1 | One maintenance operation completed |

## Verification
The bench drives a device store and then sends early acknowledgments while a barrier waits on it: a design that merged the two store counters would release the barrier early and let the held store through. A stores-only ordering barrier is followed by loads, which must flow, and a loads-only barrier is left pending with an earlier store still outstanding: a design that mixed up the options would either block loads or never retire. A synchronization barrier with a maintenance operation outstanding is tried with both the full and the loads-only option, which exposes a design that ignores maintenance or waits on it with the wrong option. The bench also fills the load counter to its limit, sends completion pulses with the counters at zero and offers a second barrier while one is pending. Each of these would show up as a wrong stall, a wrong strobe or a missing or doubled flush cycle.

// File: rtl/membar_pkg.sv
`timescale 1ns/1ps
package membar_pkg;

    typedef enum logic [1:0] {
        CLS_ALU   = 2'b00,
        CLS_LOAD  = 2'b01,
        CLS_STORE = 2'b10,
        CLS_MAINT = 2'b11
    } cls_e;

    typedef enum logic [1:0] {
        BAR_NONE   = 2'b00,
        BAR_ORDER  = 2'b01,
        BAR_SYNC   = 2'b10,
        BAR_RESYNC = 2'b11
    } bar_e;

    typedef enum logic [1:0] {
        OPT_FULL   = 2'b00,
        OPT_LOADS  = 2'b01,
        OPT_STORES = 2'b10,
        OPT_RSVD   = 2'b11
    } opt_e;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_ORDER_WAIT  = 3'd1,
        ST_SYNC_WAIT   = 3'd2,
        ST_RESYNC_WAIT = 3'd3,
        ST_FLUSH       = 3'd4
    } state_e;

    localparam int NUM_CTR = 4;
    localparam int CTR_LD  = 0;
    localparam int CTR_SE  = 1;
    localparam int CTR_SD  = 2;
    localparam int CTR_MT  = 3;

    // Counters a pending barrier waits on, one bit per counter index.
    function automatic logic [NUM_CTR-1:0] watch_mask(bar_e kind, opt_e opt);
        logic [NUM_CTR-1:0] m;
        m = '0;
        if (kind == BAR_RESYNC) begin
            m = '1;
        end else begin
            unique case (opt)
                OPT_LOADS:  m[CTR_LD] = 1'b1;
                OPT_STORES: begin
                    m[CTR_SE] = 1'b1;
                    m[CTR_SD] = 1'b1;
                end
                default: begin
                    m[CTR_LD] = 1'b1;
                    m[CTR_SE] = 1'b1;
                    m[CTR_SD] = 1'b1;
                    m[CTR_MT] = (kind == BAR_SYNC);
                end
            endcase
        end
        return m;
    endfunction

    // Whether a pending ordering barrier holds back an instruction class.
    function automatic logic order_holds(opt_e opt, cls_e cls);
        logic h;
        unique case (cls)
            CLS_LOAD:  h = (opt != OPT_STORES);
            CLS_STORE: h = 1'b1;
            CLS_MAINT: h = (opt == OPT_FULL) || (opt == OPT_RSVD);
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/membar_cnt.sv
`timescale 1ns/1ps
module membar_cnt #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic zero
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    assign full = (cnt_q == CNT_MAX);
    assign zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(inc) - CNT_W'(dec && !zero);
        end
    end

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !full);

    // R9
    idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && zero && !inc) |=> zero);

endmodule

// File: rtl/membar_ctl.sv
`timescale 1ns/1ps
module membar_ctl
    import membar_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iss_valid,
    input  logic [1:0]         iss_cls,
    input  logic [1:0]         iss_bar,
    input  logic [1:0]         iss_opt,
    input  logic               iss_early,
    input  logic [NUM_CTR-1:0] ctr_full,
    input  logic [NUM_CTR-1:0] ctr_zero,
    output logic               iss_stall,
    output logic               mem_req,
    output logic               flush_req,
    output logic [NUM_CTR-1:0] ctr_inc
);

    state_e state_q, state_d;
    opt_e   opt_q, opt_d;
    cls_e   cls;
    bar_e   bar;
    opt_e   opt;
    bar_e   pend_kind;
    logic   is_bar;
    logic   drained;
    logic   blocked;
    logic   sat;
    logic   accept;

    assign cls    = cls_e'(iss_cls);
    assign bar    = bar_e'(iss_bar);
    assign opt    = opt_e'(iss_opt);
    assign is_bar = (bar != BAR_NONE);

    always_comb begin
        unique case (state_q)
            ST_ORDER_WAIT:  pend_kind = BAR_ORDER;
            ST_SYNC_WAIT:   pend_kind = BAR_SYNC;
            ST_RESYNC_WAIT: pend_kind = BAR_RESYNC;
            default:        pend_kind = BAR_NONE;
        endcase
    end

    assign drained = &(ctr_zero | ~watch_mask(pend_kind, opt_q));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            opt_q   <= OPT_FULL;
        end else begin
            state_q <= state_d;
            opt_q   <= opt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        opt_d   = opt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_bar) begin
                    opt_d = opt;
                    unique case (bar)
                        BAR_ORDER:  state_d = ST_ORDER_WAIT;
                        BAR_SYNC:   state_d = ST_SYNC_WAIT;
                        BAR_RESYNC: state_d = ST_RESYNC_WAIT;
                        default:    state_d = ST_IDLE;
                    endcase
                end
            end
            ST_ORDER_WAIT, ST_SYNC_WAIT: begin
                if (drained) state_d = ST_IDLE;
            end
            ST_RESYNC_WAIT: begin
                if (drained) state_d = ST_FLUSH;
            end
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:       blocked = 1'b0;
            ST_ORDER_WAIT: blocked = is_bar || order_holds(opt_q, cls);
            default:       blocked = 1'b1;
        endcase

        unique case (cls)
            CLS_LOAD:  sat = ctr_full[CTR_LD];
            CLS_STORE: sat = iss_early ? ctr_full[CTR_SE] : ctr_full[CTR_SD];
            CLS_MAINT: sat = ctr_full[CTR_MT];
            default:   sat = 1'b0;
        endcase
        sat = sat && !is_bar;

        iss_stall = iss_valid && (blocked || sat);
        accept    = iss_valid && !iss_stall;
        mem_req   = accept && !is_bar && (cls != CLS_ALU);
        flush_req = (state_q == ST_FLUSH);

        ctr_inc = '0;
        if (accept && !is_bar) begin
            unique case (cls)
                CLS_LOAD:  ctr_inc[CTR_LD] = 1'b1;
                CLS_STORE: begin
                    if (iss_early) ctr_inc[CTR_SE] = 1'b1;
                    else           ctr_inc[CTR_SD] = 1'b1;
                end
                CLS_MAINT: ctr_inc[CTR_MT] = 1'b1;
                default:   ctr_inc = '0;
            endcase
        end
    end

    // R3
    req_only_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (iss_valid && !iss_stall));

    // R6
    sync_freezes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC_WAIT && iss_valid) |-> iss_stall);

    // R10
    flush_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !flush_req);

    // R10
    flush_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(&ctr_zero));

    // R11
    one_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && iss_valid && is_bar) |-> iss_stall);

endmodule

// File: rtl/membar_gate.sv
`timescale 1ns/1ps
module membar_gate #(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iss_valid,
    input  logic [1:0] iss_cls,
    input  logic [1:0] iss_bar,
    input  logic [1:0] iss_opt,
    input  logic       iss_early,
    output logic       iss_stall,
    output logic       mem_req,
    output logic       flush_req,
    input  logic       ld_done,
    input  logic       st_ack_early,
    input  logic       st_ack_end,
    input  logic       mnt_done
);

    import membar_pkg::*;

    logic [NUM_CTR-1:0] ctr_inc;
    logic [NUM_CTR-1:0] ctr_dec;
    logic [NUM_CTR-1:0] ctr_full;
    logic [NUM_CTR-1:0] ctr_zero;

    always_comb begin
        ctr_dec         = '0;
        ctr_dec[CTR_LD] = ld_done;
        ctr_dec[CTR_SE] = st_ack_early;
        ctr_dec[CTR_SD] = st_ack_end;
        ctr_dec[CTR_MT] = mnt_done;
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        membar_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (ctr_inc[g]),
            .dec  (ctr_dec[g]),
            .full (ctr_full[g]),
            .zero (ctr_zero[g])
        );
    end

    membar_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .iss_valid(iss_valid),
        .iss_cls  (iss_cls),
        .iss_bar  (iss_bar),
        .iss_opt  (iss_opt),
        .iss_early(iss_early),
        .ctr_full (ctr_full),
        .ctr_zero (ctr_zero),
        .iss_stall(iss_stall),
        .mem_req  (mem_req),
        .flush_req(flush_req),
        .ctr_inc  (ctr_inc)
    );

endmodule

// File: tb/membar_gate_bench.sv
`timescale 1ns/1ps
module membar_gate_bench;

    localparam int CNT_W = 4;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [1:0] iss_cls = 2'b00;
    logic [1:0] iss_bar = 2'b00;
    logic [1:0] iss_opt = 2'b00;
    logic       iss_early = 1'b0;
    logic       iss_stall, mem_req, flush_req;
    logic       ld_done = 1'b0, st_ack_early = 1'b0, st_ack_end = 1'b0, mnt_done = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    int n_ld = 0, n_se = 0, n_sd = 0, n_mt = 0;
    int m_st = 0;   // 0 idle, 1 ordering, 2 sync, 3 resync, 4 flush
    int m_opt = 0;

    always #2.5 clk = ~clk;

    membar_gate #(.CNT_W(CNT_W)) u_membar_gate (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
        .iss_bar(iss_bar), .iss_opt(iss_opt), .iss_early(iss_early),
        .iss_stall(iss_stall), .mem_req(mem_req), .flush_req(flush_req),
        .ld_done(ld_done), .st_ack_early(st_ack_early), .st_ack_end(st_ack_end),
        .mnt_done(mnt_done)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive, compare outputs to the model, advance the model
    task automatic step(input logic v, input int c, input int b, input int o,
                        input logic e, input logic [3:0] dn, input string tag);
        bit blk, acc, isbar, drained, full_o;
        int ld_full;
        @(negedge clk);
        iss_valid = v; iss_cls = 2'(c); iss_bar = 2'(b); iss_opt = 2'(o); iss_early = e;
        ld_done = dn[0]; st_ack_early = dn[1]; st_ack_end = dn[2]; mnt_done = dn[3];
        #1;
        isbar = (b != 0);
        full_o = (o == 0) || (o == 3);
        blk = 0;
        if (m_st >= 2) blk = 1;
        else if (m_st == 1) begin
            if (isbar) blk = 1;
            else if (c == 1 && o_hold_loads()) blk = 1;
            else if (c == 2) blk = 1;
            else if (c == 3 && (m_opt == 0 || m_opt == 3)) blk = 1;
        end
        ld_full = 0;
        if (!isbar) begin
            if (c == 1 && n_ld == MAXC) ld_full = 1;
            if (c == 2 && e && n_se == MAXC) ld_full = 1;
            if (c == 2 && !e && n_sd == MAXC) ld_full = 1;
            if (c == 3 && n_mt == MAXC) ld_full = 1;
        end
        if (ld_full != 0) blk = 1;
        acc = v && !blk;
        chk(tag, "iss_stall", iss_stall, v && blk);
        chk(tag, "mem_req", mem_req, acc && !isbar && c != 0);
        chk(tag, "flush_req", flush_req, m_st == 4);
        // retirement condition on the current counts
        if (m_st == 3) drained = (n_ld == 0 && n_se == 0 && n_sd == 0 && n_mt == 0);
        else if (m_opt == 1) drained = (n_ld == 0);
        else if (m_opt == 2) drained = (n_se == 0 && n_sd == 0);
        else drained = (n_ld == 0 && n_se == 0 && n_sd == 0 && (m_st != 2 || n_mt == 0));
        case (m_st)
            0: if (acc && isbar) begin m_st = b; m_opt = o; end
            1, 2: if (drained) m_st = 0;
            3: if (drained) m_st = 4;
            default: m_st = 0;
        endcase
        if (dn[0] && n_ld > 0) n_ld--;
        if (dn[1] && n_se > 0) n_se--;
        if (dn[2] && n_sd > 0) n_sd--;
        if (dn[3] && n_mt > 0) n_mt--;
        if (acc && !isbar) begin
            if (c == 1) n_ld++;
            if (c == 2 && e) n_se++;
            if (c == 2 && !e) n_sd++;
            if (c == 3) n_mt++;
        end
    endtask

    function automatic bit o_hold_loads();
        return m_opt != 2;
    endfunction

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 4'h0, tag);
    endtask

    task automatic op(input int c, input logic e, input string tag);
        step(1, c, 0, 0, e, 4'h0, tag);
    endtask

    task automatic barrier(input int b, input int o, input string tag);
        step(1, 0, b, o, 0, 4'h0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset
        idle(2, "R1");
        // R9: completion pulses on empty counters, then a full sync drains at once
        step(0, 0, 0, 0, 0, 4'hF, "R9");
        barrier(2, 0, "R9");
        op(0, 0, "R9");
        op(0, 0, "R9");
        // R2: one of each class, plus class ignored on a barrier-free arithmetic op
        op(1, 0, "R2");
        op(2, 1, "R2");
        op(2, 0, "R2");
        op(3, 0, "R2");
        op(0, 0, "R2");
        // R4 / R5: ordering, full option
        barrier(1, 0, "R4");
        op(0, 0, "R4");
        op(1, 0, "R4");
        op(3, 0, "R4");
        step(1, 1, 0, 0, 0, 4'b0111, "R5");
        op(1, 0, "R5");
        op(1, 0, "R5");
        op(1, 0, "R5");
        // R8: device store waits for its endpoint response
        op(2, 0, "R8");
        barrier(1, 2, "R8");
        op(1, 0, "R4");
        for (int i = 0; i < 3; i++) step(1, 2, 0, 0, 1, 4'b0010, "R8");
        step(1, 2, 0, 0, 1, 4'b0100, "R8");
        for (int i = 0; i < 3; i++) op(2, 1, "R8");
        // R4: loads-only ordering with earlier store still outstanding
        barrier(1, 1, "R4");
        op(2, 0, "R4");
        op(3, 0, "R4");
        op(1, 0, "R4");
        for (int i = 0; i < 6; i++) step(1, 2, 0, 0, 0, 4'b0001, "R5");
        op(2, 0, "R5");
        // R7: reserved option behaves as full
        op(1, 0, "R7");
        barrier(1, 3, "R7");
        op(3, 0, "R7");
        op(3, 0, "R7");
        step(1, 3, 0, 0, 0, 4'b0001, "R7");
        op(3, 0, "R7");
        op(3, 0, "R7");
        // R6: sync full waits for maintenance and stores
        barrier(2, 0, "R6");
        for (int i = 0; i < 3; i++) op(0, 0, "R6");
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 4'b1110, "R6");
        op(0, 0, "R6");
        // R6: sync loads-only ignores outstanding maintenance
        op(3, 0, "R6");
        barrier(2, 1, "R6");
        op(0, 0, "R6");
        op(1, 0, "R6");
        op(1, 0, "R6");
        // R11: second barrier stalls while one is pending
        barrier(1, 0, "R11");
        barrier(2, 0, "R11");
        barrier(2, 0, "R11");
        step(1, 0, 2, 0, 0, 4'b1111, "R11");
        for (int i = 0; i < 4; i++) step(1, 0, 2, 0, 0, 4'b1111, "R11");
        idle(3, "R11");
        // R10: resync drains everything, flushes once
        op(2, 0, "R10");
        op(3, 0, "R10");
        barrier(3, 0, "R10");
        for (int i = 0; i < 3; i++) op(0, 0, "R10");
        step(1, 0, 0, 0, 0, 4'b0100, "R10");
        step(1, 0, 0, 0, 0, 4'b1000, "R10");
        for (int i = 0; i < 4; i++) op(0, 0, "R10");
        // R12: load counter saturates
        for (int i = 0; i < MAXC + 2; i++) op(1, 0, "R12");
        step(1, 1, 0, 0, 0, 4'b0001, "R12");
        op(1, 0, "R12");
        op(1, 0, "R12");
        for (int i = 0; i < MAXC + 2; i++) step(0, 0, 0, 0, 0, 4'b0001, "R12");
        barrier(2, 0, "R12");
        idle(3, "R12");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule